// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a single-clock static memory with a 2-bit burst address generator. Every control and data input except output enable and sleep is captured on the rising clock edge. An access cycle starts when either of two active-low address strobes is asserted while the chip is selected. One is a processor-side strobe and the other a controller-side strobe. The captured address becomes the burst base. Later cycles with no strobe continue the burst. In each of those cycles the low two address bits come from the base and an internal step count. The count moves only when the advance input is low.

Reads are available in two timings, chosen by a mode pin. In flow-through timing the data path is combinational from the registered address. In pipelined timing the data passes through one more output register. Writes update either the selected byte lanes or the whole word. Output drive follows single-cycle deselect rules and is also gated by an asynchronous output enable and a sleep input. The write data port and the read data port are separate, and `dout_en_o` marks when the read port is driven. Read data is zero whenever `dout_en_o` is low.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dout_en_o` is low and `rdata_o` is zero until a read has been captured.
- R2: The chip is selected only when `ce_a_ni`=0, `ce_b_i`=1 and `ce_c_ni`=0, and the enables are looked at only in cycles where a strobe is low. A strobe cycle with the chip not selected ends the burst and forces `dout_en_o` low from the very next cycle in both timings. Enable changes in cycles without a strobe have no effect.
- R3: With `pipe_i`=0, read data for an address captured at edge N is on `rdata_o` in the cycle that follows edge N. A burst therefore delivers in 2-1-1-1 cycles.
- R4: With `pipe_i`=1, read data for an address captured at edge N is on `rdata_o` in the cycle that follows edge N+1. A burst therefore delivers in 3-1-1-1 cycles.
- R5: With `ilv_i`=0, the low two address bits of burst step k are (base + k) mod 4. The upper bits stay those of the base.
- R6: With `ilv_i`=1, the low two address bits of burst step k are base XOR k.
- R7: In a continuation cycle the step count increments only when `adv_ni`=0. With `adv_ni`=1 the cycle accesses the same address again.
- R8: With `gwe_ni`=1 and `bwe_ni`=0, exactly the lanes whose `lane_we_ni` bit is 0 are written. Lane g is `wdata_i[8g+7:8g]`. If no lane bit is 0, the cycle is a read.
- R9: `gwe_ni`=0 writes all four lanes, whatever `bwe_ni` and `lane_we_ni` are.
- R10: When both strobes are low together, the processor-side strobe wins: the cycle is a read and the write controls are ignored. A controller-side-only start, or a continuation cycle, takes its direction from the write controls.
- R11: `oe_ni`=1 forces `dout_en_o` low without a clock edge. When `oe_ni` returns to 0, the output shows the current read data again.
- R12: While `sleep_i`=1, `dout_en_o` is low. No edge changes the memory, the burst state or the output register. After sleep ends, the burst resumes from the address where it stopped.
- R13: A new base address may be loaded on every cycle. Back-to-back single reads or writes at different addresses each complete with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address, captured on a strobe cycle |
| wdata_i | input | DW | Write data |
| ce_a_ni | input | 1 | Chip enable A, active low |
| ce_b_i | input | 1 | Chip enable B, active high |
| ce_c_ni | input | 1 | Chip enable C, active low |
| strb_p_ni | input | 1 | Processor-side address strobe, active low |
| strb_c_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| lane_we_ni | input | LANES | Per-lane write selects, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| gwe_ni | input | 1 | Global write, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| pipe_i | input | 1 | 1 = pipelined read timing, 0 = flow-through |
| ilv_i | input | 1 | 1 = interleaved burst order, 0 = linear |
| rdata_o | output | DW | Read data, zero when not driven |
| dout_en_o | output | 1 | Read port drive indicator |

## Verification
Two situations put functions of this block in the same cycle. The first is a cycle with both strobes low and the global write asserted. The bench drives that cycle and then reads the same word back, to show that nothing was stored and that the cycle returned read data. The second is a deselect that arrives while a pipelined read is still held in the output register. The bench issues the deselect right after a burst read and checks that the drive drops in the next cycle, although the register still holds data. Separately, sleep is raised in the middle of a write burst that is advancing. Afterwards the memory must be unchanged, and the burst must resume at the address it had reached.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          cont_i,
  input  logic          step_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    cnt_o
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d, lo;

  always_comb begin
    base_d = load_i ? base_i : base_q;
    if (load_i)               cnt_d = 2'd0;
    else if (cont_i && step_i) cnt_d = cnt_q + 2'd1;
    else                      cnt_d = cnt_q;
    lo     = ilv_i ? (base_d[1:0] ^ cnt_d) : (base_d[1:0] + cnt_d);
    addr_o = {base_d[AW-1:2], lo};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbs_rd_path.sv
module sbs_rd_path #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pipe_i,
  input  logic          rd_now_i,
  input  logic          idle_now_i,
  input  logic [DW-1:0] mem_i,
  output logic          drive_o,
  output logic [DW-1:0] data_o
);
  logic          rd_pipe_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pipe_q <= 1'b0;
      out_q     <= '0;
    end else if (en_i) begin
      rd_pipe_q <= rd_now_i;
      out_q     <= mem_i;
    end
  end

  // single-cycle deselect: an idle capture kills the pipelined drive at once
  assign drive_o = pipe_i ? (rd_pipe_q & ~idle_now_i) : rd_now_i;
  assign data_o  = pipe_i ? out_q : mem_i;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter  int DEPTH = 256,
  parameter  int DW    = 32,
  parameter  int LANES = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = DW / LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ce_a_ni,
  input  logic             ce_b_i,
  input  logic             ce_c_ni,
  input  logic             strb_p_ni,
  input  logic             strb_c_ni,
  input  logic             adv_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             bwe_ni,
  input  logic             gwe_ni,
  input  logic             oe_ni,
  input  logic             sleep_i,
  input  logic             pipe_i,
  input  logic             ilv_i,
  output logic [DW-1:0]    rdata_o,
  output logic             dout_en_o
);
  logic             en, sel, stb, load, dsel, cont, active_q, drive;
  logic [LANES-1:0] wmask;
  acc_e             acc_d, acc_q;
  logic [AW-1:0]    acc_addr, acc_addr_q;
  logic [1:0]       cnt_w;
  logic [DW-1:0]    mem_rd, path_data;

  assign en   = ~sleep_i;
  assign sel  = ~ce_a_ni & ce_b_i & ~ce_c_ni;
  assign stb  = ~strb_p_ni | ~strb_c_ni;
  assign load = stb & sel;
  assign dsel = stb & ~sel;
  assign cont = ~stb & active_q;

  always_comb begin
    if (load && !strb_p_ni) wmask = '0;  // processor strobe forces a read
    else if (!gwe_ni)       wmask = '1;
    else if (!bwe_ni)       wmask = ~lane_we_ni;
    else                    wmask = '0;
    if (load || cont) acc_d = (|wmask) ? ACC_WR : ACC_RD;
    else              acc_d = ACC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      acc_q      <= ACC_NONE;
      acc_addr_q <= '0;
    end else if (en) begin
      if (load)      active_q <= 1'b1;
      else if (dsel) active_q <= 1'b0;
      acc_q      <= acc_d;
      acc_addr_q <= acc_addr;
    end
  end

  sbs_burst_gen #(.AW(AW)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (load),
    .cont_i (cont),
    .step_i (~adv_ni),
    .ilv_i  (ilv_i),
    .base_i (addr_i),
    .addr_o (acc_addr),
    .cnt_o  (cnt_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_mem #(.DEPTH(DEPTH), .AW(AW), .W(LW)) u_mem (
      .clk_i   (clk_i),
      .we_i    (en & (acc_d == ACC_WR) & wmask[g]),
      .waddr_i (acc_addr),
      .wdata_i (wdata_i[g*LW +: LW]),
      .raddr_i (acc_addr_q),
      .rdata_o (mem_rd[g*LW +: LW])
    );
  end

  sbs_rd_path #(.DW(DW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .pipe_i     (pipe_i),
    .rd_now_i   (acc_q == ACC_RD),
    .idle_now_i (acc_q == ACC_NONE),
    .mem_i      (mem_rd),
    .drive_o    (drive),
    .data_o     (path_data)
  );

  assign dout_en_o = drive & ~oe_ni & ~sleep_i;
  assign rdata_o   = dout_en_o ? path_data : '0;
endmodule

module sbs_chk
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_a_ni,
  input logic          ce_b_i,
  input logic          ce_c_ni,
  input logic          strb_p_ni,
  input logic          strb_c_ni,
  input logic          adv_ni,
  input logic          oe_ni,
  input logic          sleep_i,
  input logic          pipe_i,
  input logic          dout_en_o,
  input logic [1:0]    cnt_w,
  input logic [AW-1:0] acc_addr_q,
  input acc_e          acc_q
);
  logic sel_c;
  assign sel_c = ~ce_a_ni & ce_b_i & ~ce_c_ni;

  // R2
  desel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!strb_p_ni || !strb_c_ni) && !sel_c && !sleep_i) |=> !dout_en_o);

  // R3
  flow_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && !strb_p_ni && sel_c && !sleep_i)
      |=> (pipe_i || oe_ni || sleep_i || dout_en_o));

  // R4
  pipe_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && !strb_p_ni && sel_c && !sleep_i)
      ##1 (!sleep_i && ((strb_p_ni && strb_c_ni) || sel_c))
      |=> (!pipe_i || oe_ni || sleep_i || dout_en_o));

  // R7
  adv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_p_ni && strb_c_ni && adv_ni && !sleep_i) |=> $stable(cnt_w));

  // R10
  p_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_p_ni && !strb_c_ni && sel_c && !sleep_i) |=> (acc_q == ACC_RD));

  // R12
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(acc_addr_q) && $stable(cnt_w)));
endmodule

bind sync_burst_sram sbs_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_a_ni    (ce_a_ni),
  .ce_b_i     (ce_b_i),
  .ce_c_ni    (ce_c_ni),
  .strb_p_ni  (strb_p_ni),
  .strb_c_ni  (strb_c_ni),
  .adv_ni     (adv_ni),
  .oe_ni      (oe_ni),
  .sleep_i    (sleep_i),
  .pipe_i     (pipe_i),
  .dout_en_o  (dout_en_o),
  .cnt_w      (cnt_w),
  .acc_addr_q (acc_addr_q),
  .acc_q      (acc_q)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic          p_n = 1'b1, c_n = 1'b1, adv_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          bw_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, slp = 1'b0;
  logic          pipe = 1'b1, ilv = 1'b1;
  logic [31:0]   rdata;
  logic          den;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ce_a_ni(ce_a_n), .ce_b_i(ce_b), .ce_c_ni(ce_c_n),
    .strb_p_ni(p_n), .strb_c_ni(c_n), .adv_ni(adv_n),
    .lane_we_ni(lane_n), .bwe_ni(bw_n), .gwe_ni(gw_n),
    .oe_ni(oe_n), .sleep_i(slp), .pipe_i(pipe), .ilv_i(ilv),
    .rdata_o(rdata), .dout_en_o(den)
  );

  // behavioural reference
  logic [31:0] m_mem [DEPTH];
  int          m_base, m_cnt, m_acc, m_kind, m_active;
  bit          m_rd_pipe;
  logic [31:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_cnt = 0; m_acc = 0; m_kind = 0; m_active = 0;
      m_rd_pipe = 0; m_out = '0;
    end else if (!slp) begin
      bit sel, stb, load, dsl, cont;
      logic [3:0] mask;
      int lo, acc;
      sel  = !ce_a_n && ce_b && !ce_c_n;
      stb  = !p_n || !c_n;
      load = stb && sel;
      dsl  = stb && !sel;
      cont = !stb && (m_active != 0);
      if (load) begin m_base = int'(addr); m_cnt = 0; end
      else if (cont && !adv_n) m_cnt = (m_cnt + 1) % 4;
      lo  = ilv ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
      acc = m_base - (m_base % 4) + lo;
      if (load && !p_n) mask = 4'h0;
      else if (!gw_n)   mask = 4'hF;
      else if (!bw_n)   mask = ~lane_n;
      else              mask = 4'h0;
      m_out     = m_mem[m_acc];
      m_rd_pipe = (m_kind == 1);
      if (load || cont) begin
        for (int g = 0; g < 4; g++)
          if (mask[g]) m_mem[acc][g*8 +: 8] = wdata[g*8 +: 8];
        m_kind = (mask != 0) ? 2 : 1;
      end else begin
        m_kind = 0;
      end
      m_acc = acc;
      if (load) m_active = 1;
      else if (dsl) m_active = 0;
    end
  end

  always @(negedge clk) begin
    bit exp_en;
    logic [31:0] exp_d;
    exp_en = (pipe ? (m_rd_pipe && m_kind != 0) : (m_kind == 1)) && !oe_n && !slp;
    exp_d  = exp_en ? (pipe ? m_out : m_mem[m_acc]) : 32'h0;
    n_chk += 2;
    if (den !== exp_en) begin
      n_err++;
      $display("FAIL %s dout_en_o actual=%0b expected=%0b t=%0t", cur_req, den, exp_en, $time);
    end
    if (rdata !== exp_d) begin
      n_err++;
      $display("FAIL %s rdata_o actual=%08h expected=%08h t=%0t", cur_req, rdata, exp_d, $time);
    end
  end

  task automatic drive(input string req, input bit p = 0, input bit c = 0,
                       input bit adv = 0, input bit gw = 0, input bit bw = 0,
                       input logic [3:0] ln = 4'h0, input int a = 0,
                       input logic [31:0] d = 32'h0, input bit desel = 0,
                       input bit oe_off = 0, input bit sl = 0);
    @(negedge clk);
    #1;
    cur_req = req;
    p_n = ~p; c_n = ~c; adv_n = ~adv; gw_n = ~gw; bw_n = ~bw;
    lane_n = ~ln; addr = AW'(a); wdata = d;
    ce_b = ~desel; oe_n = oe_off; slp = sl;
  endtask

  task automatic read_burst(input string req, input int base);
    drive(req, .p(1), .a(base));
    for (int k = 0; k < 3; k++) drive(req, .adv(1));
    drive(req);
    drive("R2", .c(1), .desel(1));
    drive(req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    drive("R1"); drive("R1");
    // R13 back-to-back writes, one new address per cycle
    for (int a = 0; a < 32; a++) drive("R13", .c(1), .gw(1), .a(a), .d(32'h1000_0000 + a * 32'h0101_0103));
    // R13 back-to-back reads
    for (int a = 0; a < 6; a++) drive("R13", .p(1), .a(a));
    drive("R2", .c(1), .desel(1));
    // R8 byte lanes 0 and 2
    drive("R8", .c(1), .bw(1), .ln(4'b0101), .a(5), .d(32'hAABB_CCDD));
    drive("R8", .c(1), .bw(1), .ln(4'b0000), .a(7), .d(32'hFFFF_FFFF));
    drive("R8", .p(1), .a(5)); drive("R8", .p(1), .a(7)); drive("R8");
    // R9 global write overrides lane selects
    drive("R9", .c(1), .gw(1), .bw(1), .ln(4'b0001), .a(6), .d(32'hDEAD_BEEF));
    drive("R9", .p(1), .a(6)); drive("R9"); drive("R2", .c(1), .desel(1));
    // R4 / R6 pipelined interleaved burst from base 5
    read_burst("R6", 5);
    read_burst("R4", 12);
    // R5 linear
    ilv = 1'b0;
    read_burst("R5", 5);
    read_burst("R5", 14);
    // R7 advance control, with enable changes in non-strobe cycles (R2)
    drive("R7", .p(1), .a(9));
    drive("R7"); drive("R7", .desel(1)); drive("R7", .adv(1));
    drive("R7"); drive("R7", .adv(1)); drive("R7", .adv(1));
    drive("R2", .c(1), .desel(1)); drive("R2");
    // R3 flow-through
    pipe = 1'b0;
    drive("R3");
    read_burst("R3", 13);
    ilv = 1'b1;
    read_burst("R3", 18);
    drive("R13", .p(1), .a(20)); drive("R13", .p(1), .a(21)); drive("R13", .p(1), .a(22));
    // R10 both strobes with global write: must read, store nothing
    drive("R10", .p(1), .c(1), .gw(1), .a(3), .d(32'h0));
    drive("R10", .p(1), .a(3));
    drive("R10", .c(1), .bw(1), .ln(4'b1000), .a(3), .d(32'h5A00_0000));
    drive("R10", .c(1), .a(3));
    // R10 controller-started write burst, continued with global write (linear)
    ilv = 1'b0;
    drive("R10", .c(1), .gw(1), .a(25), .d(32'h2525_2525));
    for (int k = 0; k < 3; k++) drive("R10", .adv(1), .gw(1), .d(32'h7700_0000 + k));
    read_burst("R10", 25);
    // R11 output enable
    drive("R11", .p(1), .a(16));
    drive("R11", .adv(1), .oe_off(1)); drive("R11", .adv(1)); drive("R11", .oe_off(1));
    drive("R11");
    // R12 sleep in the middle of a write burst, pipelined
    pipe = 1'b1;
    drive("R12", .c(1), .gw(1), .a(28), .d(32'hC0DE_0000));
    drive("R12", .adv(1), .gw(1), .d(32'hC0DE_0001));
    drive("R12", .adv(1), .gw(1), .d(32'hBAD0_0000), .sl(1));
    drive("R12", .c(1), .gw(1), .a(0), .d(32'hBAD0_0001), .sl(1));
    drive("R12", .adv(1), .gw(1), .d(32'hC0DE_0002));
    drive("R12", .adv(1), .gw(1), .d(32'hC0DE_0003));
    read_burst("R12", 28);
    drive("R12", .p(1), .a(0));
    drive("R12", .p(1), .a(1), .sl(1));
    drive("R12"); drive("R12"); drive("R12");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule